// File: doc/BRIEF.md
# Remote Operand Buffer with Sticky Stack-Pointer Entries

This buffer sits inside one cluster of a clustered out-of-order core. It holds local copies of source operands whose producers live in another cluster's register file. Local issue logic can then find such a value by physical tag, without going back over the intercluster path each time it is needed. Renaming, cluster assignment and the register files are outside this block.

There are two pools. The general pool holds ordinary remote operands, from 4 to 6 entries, and defaults to 4. An allocation in the general pool starts a remote read, and the value arrives one cycle later. A general entry is released when its single consumer reads it. The stack-pointer pool has exactly two entries, and ordinary operands never use them. A stack-pointer producer gets its entry when it is dispatched, before its result exists. Its completion fills the entry. The entry survives any number of reads and is freed only when a newer stack-pointer producer commits. A flush drops every entry whose producer has not committed.

Top module: `remote_opnd_buf`

## Requirements
- R1: After reset every entry is empty. A lookup misses, no remote read is requested, and an allocation is accepted.
- R2: An accepted general allocation (`alloc_sp_i`=0) raises `rmt_req_o` with `rmt_tag_o` equal to the allocated tag in the same cycle. In the next cycle a lookup of that tag hits with ready low. The `rmt_data_i` value present in that next cycle is captured, and from the following cycle a lookup returns it with ready high.
- R3: While all GEN_N general entries are valid, a general allocation is refused. `alloc_stall_o` is 1, `rmt_req_o` is 0, and the tag is not stored.
- R4: A lookup that hits a ready general entry releases it, so a later lookup of that tag misses. A lookup that finds the entry not ready leaves it in place.
- R5: A stack-pointer allocation (`alloc_sp_i`=1) uses only the two reserved entries. It is accepted while the general pool is full, and it never raises `rmt_req_o`.
- R6: A stack-pointer entry hits with ready low until a completion with its tag arrives. From the next cycle it is ready with the completion data.
- R7: Reading a stack-pointer entry does not release it. It keeps hitting for every later reader.
- R8: When a stack-pointer producer commits, the other stack-pointer entry is freed if it holds an already committed (older) value. The committing entry stays valid.
- R9: While both stack-pointer entries are valid, a stack-pointer allocation stalls. It is accepted once a commit has freed one of them.
- R10: `flush_i` invalidates all general entries and every uncommitted stack-pointer entry. A committed stack-pointer entry stays. An allocation presented in the flush cycle is refused with `alloc_stall_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Allocation request |
| alloc_sp_i | input | 1 | 1 selects the stack-pointer pool, 0 the general pool |
| alloc_tag_i | input | TAG_W | Physical tag to allocate |
| alloc_stall_o | output | 1 | Allocation refused this cycle |
| rmt_req_o | output | 1 | Remote register read request |
| rmt_tag_o | output | TAG_W | Tag of the remote read |
| rmt_data_i | input | DATA_W | Remote read data, one cycle after the request |
| cmpl_valid_i | input | 1 | Stack-pointer producer completion |
| cmpl_tag_i | input | TAG_W | Completing tag |
| cmpl_data_i | input | DATA_W | Completion result |
| sp_commit_i | input | 1 | Stack-pointer producer commit |
| sp_commit_tag_i | input | TAG_W | Committing tag |
| flush_i | input | 1 | Squash all speculative entries |
| lkp_valid_i | input | 1 | Lookup from issue logic |
| lkp_tag_i | input | TAG_W | Tag looked up |
| lkp_hit_o | output | 1 | Tag present |
| lkp_ready_o | output | 1 | Present and value available |
| lkp_data_o | output | DATA_W | Operand value |

## Verification
The valid bits are only visible through lookups. A general entry that is never released shows up as a false hit, and it also makes a later allocation stall one entry too early. A stack-pointer entry freed too soon shows as a miss on the very next lookup. A ready bit set too early or too late changes `lkp_ready_o` in the cycle right after the remote request or the completion. A missed flush shows on the first lookup after the flush cycle.

// File: rtl/remote_opnd_buf_pkg.sv
package remote_opnd_buf_pkg;
  localparam int unsigned SP_ENTRIES = 2;
  typedef enum logic [0:0] { POOL_GEN = 1'b0, POOL_SP = 1'b1 } pool_e;
endpackage

// File: rtl/rob_first_free.sv
module rob_first_free #(
  parameter int unsigned N = 4,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     busy_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/rob_tag_cam.sv
module rob_tag_cam #(
  parameter int unsigned N     = 4,
  parameter int unsigned TAG_W = 7
) (
  input  logic [N-1:0]            vld_i,
  input  logic [N-1:0][TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0]        key_i,
  output logic [N-1:0]            match_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_o[g] = vld_i[g] && (tag_i[g] == key_i);
  end
endmodule

// File: rtl/remote_opnd_buf.sv
module remote_opnd_buf
  import remote_opnd_buf_pkg::*;
#(
  parameter int unsigned GEN_N  = 4,
  parameter int unsigned TAG_W  = 7,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_valid_i,
  input  logic              alloc_sp_i,
  input  logic [TAG_W-1:0]  alloc_tag_i,
  output logic              alloc_stall_o,
  output logic              rmt_req_o,
  output logic [TAG_W-1:0]  rmt_tag_o,
  input  logic [DATA_W-1:0] rmt_data_i,
  input  logic              cmpl_valid_i,
  input  logic [TAG_W-1:0]  cmpl_tag_i,
  input  logic [DATA_W-1:0] cmpl_data_i,
  input  logic              sp_commit_i,
  input  logic [TAG_W-1:0]  sp_commit_tag_i,
  input  logic              flush_i,
  input  logic              lkp_valid_i,
  input  logic [TAG_W-1:0]  lkp_tag_i,
  output logic              lkp_hit_o,
  output logic              lkp_ready_o,
  output logic [DATA_W-1:0] lkp_data_o
);
  localparam int unsigned SP_N   = SP_ENTRIES;
  localparam int unsigned N      = GEN_N + SP_N;
  localparam int unsigned IDX_W  = $clog2(N);
  localparam int unsigned GIDX_W = (GEN_N > 1) ? $clog2(GEN_N) : 1;

  logic [N-1:0]              vld_q, rdy_q, cmt_q;
  logic [N-1:0][TAG_W-1:0]   tag_q;
  logic [N-1:0][DATA_W-1:0]  data_q;
  logic                      pend_q;
  logic [IDX_W-1:0]          pend_idx_q;

  logic                      gen_free, sp_free;
  logic [GIDX_W-1:0]         gen_idx;
  logic                      sp_idx;
  logic                      alloc_is_sp, alloc_go;
  logic [IDX_W-1:0]          alloc_idx;
  logic [N-1:0]              lkp_match, hit_vec;
  logic [SP_N-1:0]           cmpl_hit, cmt_hit, old_free;

  rob_first_free #(.N(GEN_N)) u_gen_pick (
    .busy_i (vld_q[GEN_N-1:0]),
    .found_o(gen_free),
    .idx_o  (gen_idx)
  );

  rob_first_free #(.N(SP_N)) u_sp_pick (
    .busy_i (vld_q[N-1:GEN_N]),
    .found_o(sp_free),
    .idx_o  (sp_idx)
  );

  rob_tag_cam #(.N(N), .TAG_W(TAG_W)) u_lkp_cam (
    .vld_i  (vld_q),
    .tag_i  (tag_q),
    .key_i  (lkp_tag_i),
    .match_o(lkp_match)
  );

  rob_tag_cam #(.N(SP_N), .TAG_W(TAG_W)) u_cmpl_cam (
    .vld_i  (vld_q[N-1:GEN_N]),
    .tag_i  (tag_q[N-1:GEN_N]),
    .key_i  (cmpl_tag_i),
    .match_o(cmpl_hit)
  );

  rob_tag_cam #(.N(SP_N), .TAG_W(TAG_W)) u_cmt_cam (
    .vld_i  (vld_q[N-1:GEN_N]),
    .tag_i  (tag_q[N-1:GEN_N]),
    .key_i  (sp_commit_tag_i),
    .match_o(cmt_hit)
  );

  assign alloc_is_sp   = (pool_e'(alloc_sp_i) == POOL_SP);
  assign alloc_go      = alloc_valid_i && !flush_i && (alloc_is_sp ? sp_free : gen_free);
  assign alloc_stall_o = alloc_valid_i && !alloc_go;
  assign alloc_idx     = alloc_is_sp ? IDX_W'(GEN_N) + IDX_W'(sp_idx) : IDX_W'(gen_idx);
  assign rmt_req_o     = alloc_go && !alloc_is_sp;
  assign rmt_tag_o     = alloc_tag_i;

  assign hit_vec   = lkp_match & {N{lkp_valid_i}};
  assign lkp_hit_o = |hit_vec;

  // lowest matching index wins
  always_comb begin
    lkp_ready_o = 1'b0;
    lkp_data_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        lkp_ready_o = rdy_q[i];
        lkp_data_o  = data_q[i];
      end
    end
  end

  // a commit retires the other, already committed, stack-pointer value
  for (genvar j = 0; j < SP_N; j++) begin : g_old
    assign old_free[j] = sp_commit_i && (|cmt_hit) && !cmt_hit[j]
                         && vld_q[GEN_N+j] && cmt_q[GEN_N+j];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q      <= '0;
      rdy_q      <= '0;
      cmt_q      <= '0;
      tag_q      <= '0;
      data_q     <= '0;
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
    end else begin
      if (pend_q) begin
        rdy_q[pend_idx_q]  <= 1'b1;
        data_q[pend_idx_q] <= rmt_data_i;
      end
      pend_q     <= rmt_req_o;
      pend_idx_q <= alloc_idx;

      for (int i = 0; i < GEN_N; i++) begin
        if (hit_vec[i] && rdy_q[i]) vld_q[i] <= 1'b0;
      end

      for (int j = 0; j < SP_N; j++) begin
        if (cmpl_valid_i && cmpl_hit[j]) begin
          rdy_q[GEN_N+j]  <= 1'b1;
          data_q[GEN_N+j] <= cmpl_data_i;
        end
        if (sp_commit_i && cmt_hit[j]) cmt_q[GEN_N+j] <= 1'b1;
        if (old_free[j]) vld_q[GEN_N+j] <= 1'b0;
      end

      if (alloc_go) begin
        vld_q[alloc_idx] <= 1'b1;
        rdy_q[alloc_idx] <= 1'b0;
        cmt_q[alloc_idx] <= 1'b0;
        tag_q[alloc_idx] <= alloc_tag_i;
      end

      if (flush_i) begin
        pend_q <= 1'b0;
        for (int i = 0; i < N; i++) begin
          if (!cmt_q[i]) vld_q[i] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/remote_opnd_buf_chk.sv
module remote_opnd_buf_chk #(
  parameter int unsigned GEN_N = 4,
  parameter int unsigned N     = 6,
  parameter int unsigned TAG_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             alloc_valid_i,
  input logic             alloc_sp_i,
  input logic             alloc_stall_o,
  input logic             rmt_req_o,
  input logic [TAG_W-1:0] rmt_tag_o,
  input logic             flush_i,
  input logic             sp_commit_i,
  input logic             lkp_valid_i,
  input logic [TAG_W-1:0] lkp_tag_i,
  input logic             lkp_hit_o,
  input logic             lkp_ready_o,
  input logic [N-1:0]     vld_q,
  input logic [N-1:0]     rdy_q,
  input logic [N-1:0]     cmt_q,
  input logic [N-1:0]     hit_vec
);
  p_fill_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rmt_req_o |=> (!(lkp_valid_i && lkp_tag_i == $past(rmt_tag_o)) || (lkp_hit_o && !lkp_ready_o)));

  p_gen_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_valid_i && !alloc_sp_i && (&vld_q[GEN_N-1:0])) |-> (alloc_stall_o && !rmt_req_o));

  for (genvar i = 0; i < GEN_N; i++) begin : g_gen
    p_gen_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_vec[i] && rdy_q[i]) |=> !vld_q[i]);
  end

  p_sp_no_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_valid_i && alloc_sp_i) |-> !rmt_req_o);

  for (genvar i = GEN_N; i < N; i++) begin : g_sp
    p_sp_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_vec[i] && !flush_i && !sp_commit_i) |=> vld_q[i]);
  end

  p_sp_full_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_valid_i && alloc_sp_i && (&vld_q[N-1:GEN_N])) |-> alloc_stall_o);

  p_flush_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> ((vld_q & ~cmt_q) == '0));
endmodule

bind remote_opnd_buf remote_opnd_buf_chk #(.GEN_N(GEN_N), .N(N), .TAG_W(TAG_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .alloc_valid_i(alloc_valid_i),
  .alloc_sp_i   (alloc_sp_i),
  .alloc_stall_o(alloc_stall_o),
  .rmt_req_o    (rmt_req_o),
  .rmt_tag_o    (rmt_tag_o),
  .flush_i      (flush_i),
  .sp_commit_i  (sp_commit_i),
  .lkp_valid_i  (lkp_valid_i),
  .lkp_tag_i    (lkp_tag_i),
  .lkp_hit_o    (lkp_hit_o),
  .lkp_ready_o  (lkp_ready_o),
  .vld_q        (vld_q),
  .rdy_q        (rdy_q),
  .cmt_q        (cmt_q),
  .hit_vec      (hit_vec)
);

// File: tb/remote_opnd_buf_tb.sv
module remote_opnd_buf_tb;
  localparam int unsigned TAG_W  = 7;
  localparam int unsigned DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_ni;
  logic              alloc_valid_i, alloc_sp_i, alloc_stall_o;
  logic [TAG_W-1:0]  alloc_tag_i;
  logic              rmt_req_o;
  logic [TAG_W-1:0]  rmt_tag_o;
  logic [DATA_W-1:0] rmt_data_i;
  logic              cmpl_valid_i;
  logic [TAG_W-1:0]  cmpl_tag_i;
  logic [DATA_W-1:0] cmpl_data_i;
  logic              sp_commit_i;
  logic [TAG_W-1:0]  sp_commit_tag_i;
  logic              flush_i;
  logic              lkp_valid_i;
  logic [TAG_W-1:0]  lkp_tag_i;
  logic              lkp_hit_o, lkp_ready_o;
  logic [DATA_W-1:0] lkp_data_o;

  int unsigned       checks = 0, fails = 0;
  logic [DATA_W-1:0] nxt_fill = '0;
  bit                done = 1'b0;

  always #4 clk = ~clk;

  remote_opnd_buf u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .alloc_valid_i(alloc_valid_i), .alloc_sp_i(alloc_sp_i), .alloc_tag_i(alloc_tag_i),
    .alloc_stall_o(alloc_stall_o), .rmt_req_o(rmt_req_o), .rmt_tag_o(rmt_tag_o),
    .rmt_data_i(rmt_data_i), .cmpl_valid_i(cmpl_valid_i), .cmpl_tag_i(cmpl_tag_i),
    .cmpl_data_i(cmpl_data_i), .sp_commit_i(sp_commit_i), .sp_commit_tag_i(sp_commit_tag_i),
    .flush_i(flush_i), .lkp_valid_i(lkp_valid_i), .lkp_tag_i(lkp_tag_i),
    .lkp_hit_o(lkp_hit_o), .lkp_ready_o(lkp_ready_o), .lkp_data_o(lkp_data_o)
  );

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // new cycle: remote data of the previous request goes out now
  task automatic cyc();
    @(negedge clk);
    alloc_valid_i = 0; alloc_sp_i = 0; alloc_tag_i = '0;
    cmpl_valid_i = 0; cmpl_tag_i = '0; cmpl_data_i = '0;
    sp_commit_i = 0; sp_commit_tag_i = '0; flush_i = 0;
    lkp_valid_i = 0; lkp_tag_i = '0;
    rmt_data_i = nxt_fill; nxt_fill = '0;
  endtask

  task automatic op_alloc(bit sp, int tag, logic [DATA_W-1:0] d, bit exp_stall, string req);
    cyc();
    alloc_valid_i = 1; alloc_sp_i = sp; alloc_tag_i = TAG_W'(tag);
    if (!sp && !exp_stall) nxt_fill = d;
    #1;
    check(req, "alloc_stall_o", alloc_stall_o, exp_stall);
    check(req, "rmt_req_o", rmt_req_o, !sp && !exp_stall);
    if (!sp && !exp_stall) check(req, "rmt_tag_o", rmt_tag_o, tag);
  endtask

  task automatic op_look(int tag, bit hit, bit rdy, logic [DATA_W-1:0] d, string req);
    cyc();
    lkp_valid_i = 1; lkp_tag_i = TAG_W'(tag);
    #1;
    check(req, $sformatf("hit tag %0d", tag), lkp_hit_o, hit);
    if (hit) check(req, $sformatf("ready tag %0d", tag), lkp_ready_o, rdy);
    if (hit && rdy) check(req, $sformatf("data tag %0d", tag), lkp_data_o, d);
  endtask

  task automatic op_cmpl(int tag, logic [DATA_W-1:0] d);
    cyc();
    cmpl_valid_i = 1; cmpl_tag_i = TAG_W'(tag); cmpl_data_i = d;
  endtask

  task automatic op_commit(int tag);
    cyc();
    sp_commit_i = 1; sp_commit_tag_i = TAG_W'(tag);
  endtask

  task automatic t_reset();
    op_look(5, 0, 0, '0, "R1");
    check("R1", "rmt_req_o idle", rmt_req_o, 0);
    op_alloc(0, 10, 32'hA0A0_0010, 0, "R1");
  endtask

  task automatic t_gen_fill();
    op_look(10, 1, 0, '0, "R2");          // in flight, not released (R4)
    op_look(10, 1, 1, 32'hA0A0_0010, "R2");
    op_look(10, 0, 0, '0, "R4");
  endtask

  task automatic t_gen_full();
    for (int k = 0; k < 4; k++) op_alloc(0, 20 + k, 32'h2000 + k, 0, "R3");
    op_alloc(0, 24, 32'hdead, 1, "R3");
    op_look(24, 0, 0, '0, "R3");
    op_alloc(1, 40, '0, 0, "R5");
    op_look(40, 1, 0, '0, "R6");
    for (int k = 0; k < 4; k++) op_look(20 + k, 1, 1, 32'h2000 + k, "R4");
    op_look(20, 0, 0, '0, "R4");
  endtask

  task automatic t_sp_sticky();
    op_cmpl(40, 32'h5000_0040);
    for (int k = 0; k < 3; k++) op_look(40, 1, 1, 32'h5000_0040, "R7");
  endtask

  task automatic t_sp_commit();
    op_commit(40);
    op_look(40, 1, 1, 32'h5000_0040, "R8");
    op_alloc(1, 41, '0, 0, "R9");
    op_alloc(1, 42, '0, 1, "R9");
    op_look(42, 0, 0, '0, "R9");
    op_cmpl(41, 32'h5000_0041);
    op_commit(41);
    op_look(40, 0, 0, '0, "R8");
    op_look(41, 1, 1, 32'h5000_0041, "R8");
    op_alloc(1, 42, '0, 0, "R9");
  endtask

  task automatic t_flush();
    op_alloc(0, 50, 32'h0000_0050, 0, "R10");
    cyc();
    flush_i = 1; alloc_valid_i = 1; alloc_tag_i = TAG_W'(51);
    #1;
    check("R10", "alloc_stall_o in flush", alloc_stall_o, 1);
    check("R10", "rmt_req_o in flush", rmt_req_o, 0);
    op_look(50, 0, 0, '0, "R10");
    op_look(42, 0, 0, '0, "R10");
    op_look(51, 0, 0, '0, "R10");
    op_look(41, 1, 1, 32'h5000_0041, "R10");
    op_alloc(1, 43, '0, 0, "R10");
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst_ni = 0;
    alloc_valid_i = 0; alloc_sp_i = 0; alloc_tag_i = '0; rmt_data_i = '0;
    cmpl_valid_i = 0; cmpl_tag_i = '0; cmpl_data_i = '0;
    sp_commit_i = 0; sp_commit_tag_i = '0; flush_i = 0;
    lkp_valid_i = 0; lkp_tag_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1;
    t_reset();
    t_gen_fill();
    t_gen_full();
    t_sp_sticky();
    t_sp_commit();
    t_flush();
    cyc();
    @(posedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule